// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts, at fetch time, whether a branch will be taken and where it goes. It is a direct-mapped table. Each entry holds a valid flag, an address tag, a target address and a two-bit direction counter. A fetch address presented on the lookup port comes back one cycle later with a hit flag, a taken prediction and the stored target. Resolved branches are fed back on the update port with their actual outcome and target.

Entries are created lazily: a branch gets an entry only the first time it is seen taken, and that entry starts at the strongest taken value. A not-taken branch that has no entry leaves the table alone, so it keeps missing and keeps being predicted not taken. The parameter `LEAP_FROM_ZERO` chooses how the counter recovers from its lowest value. When it is 0, a taken outcome moves the counter up one step. When it is 1, the counter jumps straight to the top.

Both ports carry the address above its alignment bits (`PC_W-1` down to `ALIGN_W`). Neither port has back-pressure. A lookup is accepted in every cycle in which `lk_valid` is high, and its response appears, flagged by `rsp_valid`, in the next cycle with no way to stall it. An update is accepted in every cycle in which `upd_valid` is high.

Top module: `btb_pred`

## Requirements
- R1: While reset is high, `rsp_valid` is 0. After reset, every entry is invalid, so every lookup misses until a taken update allocates an entry.
- R2: A lookup accepted at a clock edge produces `rsp_valid`=1 together with its result in the cycle after that edge. Without a lookup, `rsp_valid` is 0 in that cycle.
- R3: The counter encoding is 0 = strongly not taken, 1 = weakly not taken, 2 = weakly taken, 3 = strongly taken. A hit predicts taken exactly when the counter is 2 or 3. A miss returns `rsp_taken`=0 and `rsp_target`=0.
- R4: A taken update that misses writes the entry at its index: it becomes valid, takes the update's tag and target, and its counter is set to 3.
- R5: A not-taken update that misses changes no entry.
- R6: An update that hits moves the counter one step and holds it within 0 to 3: up on a taken outcome, down on a not-taken outcome. A taken hit also replaces the stored target. A not-taken hit keeps the stored target.
- R7: With `LEAP_FROM_ZERO`=1, a taken hit on counter 0 sets the counter to 3. With `LEAP_FROM_ZERO`=0, it sets the counter to 1.
- R8: The index is address bits [ALIGN_W+IDX_W-1:ALIGN_W] and the tag is every bit above them. A taken update whose tag differs from the valid entry at its index replaces that entry, and the previous address then misses.
- R9: When a lookup and an update reach the same index at the same edge, the lookup returns the entry as it stood before that update.
- R10: From counter 3, one not-taken outcome still leaves a taken prediction. A second consecutive not-taken outcome gives a not-taken prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W-ALIGN_W | Fetch address without alignment bits |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Address found in the table |
| rsp_taken | output | 1 | Predicted taken |
| rsp_target | output | TGT_W | Predicted target, 0 on a miss |
| upd_valid | input | 1 | Resolved branch this cycle |
| upd_pc | input | PC_W-ALIGN_W | Resolved branch address without alignment bits |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_target | input | TGT_W | Actual target of the branch |

## Verification
A lookup result is due one cycle after the edge that accepts the request. An update becomes visible to a lookup accepted at the following edge, so its effect shows up two cycles after the update was presented. A lookup that shares an edge with an update must show the older contents. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and reads the response on the next falling edge. A reference table in the bench is advanced only after each edge completes, so the expected values follow the same one-cycle latency. Two instances, one with each setting of the leap parameter, receive identical stimulus and are compared against the same arithmetic model.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    CTR_NT_STRONG = 2'd0,
    CTR_NT_WEAK   = 2'd1,
    CTR_T_WEAK    = 2'd2,
    CTR_T_STRONG  = 2'd3
  } ctr_t;
endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 4,
  localparam int ADR_W  = PC_W - ALIGN_W,
  localparam int TAG_W  = ADR_W - IDX_W
) (
  input  logic [ADR_W-1:0] adr,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = adr[IDX_W-1:0];
  assign tag = adr[ADR_W-1:IDX_W];
endmodule

// File: rtl/btb_ctr_next.sv
module btb_ctr_next
  import btb_pkg::*;
#(
  parameter bit LEAP_FROM_ZERO = 1'b0
) (
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  ctr_t up_val;

  generate
    if (LEAP_FROM_ZERO) begin : g_leap
      always_comb begin
        if (cur == CTR_NT_STRONG)     up_val = CTR_T_STRONG;
        else if (cur == CTR_T_STRONG) up_val = CTR_T_STRONG;
        else                          up_val = ctr_t'(cur + 2'd1);
      end
    end else begin : g_step
      always_comb begin
        if (cur == CTR_T_STRONG) up_val = CTR_T_STRONG;
        else                     up_val = ctr_t'(cur + 2'd1);
      end
    end
  endgenerate

  always_comb begin
    if (taken)                     nxt = up_val;
    else if (cur == CTR_NT_STRONG) nxt = CTR_NT_STRONG;
    else                           nxt = ctr_t'(cur - 2'd1);
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 26,
  parameter int TGT_W    = 32,
  parameter int RD_PORTS = 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx [RD_PORTS],
  output logic             rd_vld [RD_PORTS],
  output logic [TAG_W-1:0] rd_tag [RD_PORTS],
  output logic [TGT_W-1:0] rd_tgt [RD_PORTS],
  output ctr_t             rd_ctr [RD_PORTS],
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  ctr_t             wr_ctr
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TGT_W-1:0]   tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  generate
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_vld[p] = vld_q[rd_idx[p]];
      assign rd_tag[p] = tag_q[rd_idx[p]];
      assign rd_tgt[p] = tgt_q[rd_idx[p]];
      assign rd_ctr[p] = ctr_q[rd_idx[p]];
    end
  endgenerate
endmodule

// File: rtl/btb_pred.sv
module btb_pred
  import btb_pkg::*;
#(
  parameter int PC_W           = 32,
  parameter int ALIGN_W        = 2,
  parameter int IDX_W          = 4,
  parameter int TGT_W          = 32,
  parameter bit LEAP_FROM_ZERO = 1'b0,
  localparam int ADR_W         = PC_W - ALIGN_W,
  localparam int TAG_W         = ADR_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lk_valid,
  input  logic [PC_W-1:ALIGN_W] lk_pc,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_taken,
  output logic [TGT_W-1:0]     rsp_target,
  input  logic                 upd_valid,
  input  logic [PC_W-1:ALIGN_W] upd_pc,
  input  logic                 upd_taken,
  input  logic [TGT_W-1:0]     upd_target
);
  localparam int P_LK  = 0;
  localparam int P_UPD = 1;

  logic [IDX_W-1:0] rd_idx [2];
  logic             rd_vld [2];
  logic [TAG_W-1:0] rd_tag [2];
  logic [TGT_W-1:0] rd_tgt [2];
  ctr_t             rd_ctr [2];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  btb_pc_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_split_lk (
    .adr(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );
  btb_pc_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_split_up (
    .adr(upd_pc), .idx(up_idx), .tag(up_tag)
  );

  assign rd_idx[P_LK]  = lk_idx;
  assign rd_idx[P_UPD] = up_idx;

  logic             wr_en;
  logic [TGT_W-1:0] wr_tgt;
  ctr_t             wr_ctr, ctr_stepped;
  logic             up_hit, lk_hit;

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W), .RD_PORTS(2)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt), .rd_ctr(rd_ctr),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  btb_ctr_next #(.LEAP_FROM_ZERO(LEAP_FROM_ZERO)) u_next (
    .cur(rd_ctr[P_UPD]), .taken(upd_taken), .nxt(ctr_stepped)
  );

  // Update side: hits step the counter, taken misses (re)allocate.
  assign up_hit = rd_vld[P_UPD] && (rd_tag[P_UPD] == up_tag);
  assign wr_en  = upd_valid && (up_hit || upd_taken);
  assign wr_ctr = up_hit ? ctr_stepped : CTR_T_STRONG;
  assign wr_tgt = upd_taken ? upd_target : rd_tgt[P_UPD];

  // Lookup side: registered result reads the pre-write contents.
  assign lk_hit = rd_vld[P_LK] && (rd_tag[P_LK] == lk_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_target <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && lk_hit;
      rsp_taken  <= lk_valid && lk_hit && rd_ctr[P_LK][1];
      rsp_target <= (lk_valid && lk_hit) ? rd_tgt[P_LK] : '0;
    end
  end
endmodule

// File: rtl/btb_pred_chk.sv
module btb_pred_chk #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int TGT_W   = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lk_valid,
  input logic [PC_W-1:ALIGN_W] lk_pc,
  input logic                  rsp_valid,
  input logic                  rsp_hit,
  input logic                  rsp_taken,
  input logic [TGT_W-1:0]      rsp_target,
  input logic                  upd_valid,
  input logic [PC_W-1:ALIGN_W] upd_pc,
  input logic                  upd_taken,
  input logic [TGT_W-1:0]      upd_target
);
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)               age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2: a response follows each accepted lookup by one cycle
  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0) |-> (rsp_valid == $past(lk_valid)));

  // R3: a miss never predicts taken and returns a zero target
  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (!rsp_taken && rsp_target == '0));

  // R4: a taken update makes the next lookup of that address hit
  assert_taken_alloc_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && lk_valid && $past(upd_valid && upd_taken) && lk_pc == $past(upd_pc))
    |=> rsp_hit);

  // R6: a taken update's target is returned by the following lookup
  assert_taken_target_R6: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && lk_valid && $past(upd_valid && upd_taken) && lk_pc == $past(upd_pc))
    |=> (rsp_target == $past(upd_target, 2)));
endmodule

bind btb_pred btb_pred_chk #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_taken(rsp_taken), .rsp_target(rsp_target),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
);

// File: tb/btb_pred_tb.sv
module btb_pred_tb;
  localparam int PC_W = 32, ALIGN_W = 2, IDX_W = 4, TGT_W = 32;
  localparam int ADR_W = PC_W - ALIGN_W;
  localparam int TAG_W = ADR_W - IDX_W;
  localparam int ENT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [ADR_W-1:0] lk_pc = '0, upd_pc = '0;
  logic [TGT_W-1:0] upd_target = '0;

  logic rv0, rh0, rt0, rv1, rh1, rt1;
  logic [TGT_W-1:0] rg0, rg1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  btb_pred #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .TGT_W(TGT_W),
             .LEAP_FROM_ZERO(1'b0)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rv0), .rsp_hit(rh0), .rsp_taken(rt0), .rsp_target(rg0),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );
  btb_pred #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .TGT_W(TGT_W),
             .LEAP_FROM_ZERO(1'b1)) u_leap (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rv1), .rsp_hit(rh1), .rsp_taken(rt1), .rsp_target(rg1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  // Reference table: [0] stepping instance, [1] leaping instance
  logic             m_vld [ENT];
  logic [TAG_W-1:0] m_tag [ENT];
  logic [TGT_W-1:0] m_tgt [ENT];
  int               m_ctr [2][ENT];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int ctr_after(input int c, input bit tk, input bit leap);
    if (tk) return (leap && c == 0) ? 3 : ((c == 3) ? 3 : c + 1);
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_update(input logic [ADR_W-1:0] pc, input bit tk, input logic [TGT_W-1:0] tg);
    int i = int'(pc[IDX_W-1:0]);
    bit hit = m_vld[i] && (m_tag[i] == pc[ADR_W-1:IDX_W]);
    if (hit) begin
      for (int k = 0; k < 2; k++) m_ctr[k][i] = ctr_after(m_ctr[k][i], tk, k == 1);
      if (tk) m_tgt[i] = tg;
    end else if (tk) begin
      m_vld[i] = 1'b1;
      m_tag[i] = pc[ADR_W-1:IDX_W];
      m_tgt[i] = tg;
      for (int k = 0; k < 2; k++) m_ctr[k][i] = 3;
    end
  endtask

  // expected response computed before the edge; compared after it
  task automatic lookup(input logic [ADR_W-1:0] pc, input bit with_upd, input bit tk,
                        input logic [TGT_W-1:0] tg, input string req);
    int i = int'(pc[IDX_W-1:0]);
    bit eh = m_vld[i] && (m_tag[i] == pc[ADR_W-1:IDX_W]);
    bit et0 = eh && (m_ctr[0][i] >= 2);
    bit et1 = eh && (m_ctr[1][i] >= 2);
    logic [TGT_W-1:0] eg = eh ? m_tgt[i] : '0;
    lk_valid = 1'b1; lk_pc = pc;
    if (with_upd) begin upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg; end
    step();
    lk_valid = 1'b0; upd_valid = 1'b0;
    if (with_upd) model_update(pc, tk, tg);
    chk(req, "valid", 64'(rv0), 64'd1);
    chk(req, "hit", 64'(rh0), 64'(eh));
    chk(req, "taken", 64'(rt0), 64'(et0));
    chk(req, "target", 64'(rg0), 64'(eg));
    chk(req, "leap.hit", 64'(rh1), 64'(eh));
    chk(req, "leap.taken", 64'(rt1), 64'(et1));
    chk(req, "leap.target", 64'(rg1), 64'(eg));
  endtask

  task automatic update(input logic [ADR_W-1:0] pc, input bit tk, input logic [TGT_W-1:0] tg);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
    step();
    upd_valid = 1'b0;
    model_update(pc, tk, tg);
  endtask

  function automatic logic [ADR_W-1:0] mk(input int tag, input int idx);
    return {TAG_W'(tag), IDX_W'(idx)};
  endfunction

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[0][i] = 0; m_ctr[1][i] = 0;
    end
    // R1: response quiet during reset even with a lookup pending
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = mk(1, 1);
    step(); step();
    chk("R1", "rsp_valid in reset", 64'(rv0 | rv1), 64'd0);
    lk_valid = 1'b0;
    rst = 1'b0;
    step();
    // R2: no lookup means no response
    chk("R2", "idle rsp_valid", 64'(rv0 | rv1), 64'd0);
    // R1: every index misses after reset
    for (int i = 0; i < ENT; i++) lookup(mk(5, i), 1'b0, 1'b0, '0, "R1");

    // R5: not-taken miss does not allocate
    update(mk(7, 3), 1'b0, 32'hAAAA_0000);
    lookup(mk(7, 3), 1'b0, 1'b0, '0, "R5");
    chk("R5", "no alloc", 64'(rh0 | rh1), 64'd0);
    // R4: taken miss allocates at counter 3 with its target
    update(mk(7, 3), 1'b1, 32'h0000_1234);
    lookup(mk(7, 3), 1'b0, 1'b0, '0, "R4");
    chk("R4", "alloc target", 64'(rg0), 64'h1234);
    chk("R4", "alloc taken", 64'(rt0 & rt1), 64'd1);
    // R10: one not-taken keeps taken, second flips it
    update(mk(7, 3), 1'b0, 32'h0);
    lookup(mk(7, 3), 1'b0, 1'b0, '0, "R10");
    chk("R10", "after one NT", 64'(rt0), 64'd1);
    update(mk(7, 3), 1'b0, 32'h0);
    lookup(mk(7, 3), 1'b0, 1'b0, '0, "R10");
    chk("R10", "after two NT", 64'(rt0), 64'd0);
    chk("R6", "NT keeps target", 64'(rg0), 64'h1234);
    // R6: saturate at 0
    update(mk(7, 3), 1'b0, 32'h0);
    update(mk(7, 3), 1'b0, 32'h0);
    lookup(mk(7, 3), 1'b0, 1'b0, '0, "R6");
    // R7: taken from 0: stepping predicts not taken, leaping predicts taken
    update(mk(7, 3), 1'b1, 32'h0000_5678);
    lookup(mk(7, 3), 1'b0, 1'b0, '0, "R7");
    chk("R7", "step from 0", 64'(rt0), 64'd0);
    chk("R7", "leap from 0", 64'(rt1), 64'd1);
    chk("R6", "taken rewrites target", 64'(rg1), 64'h5678);
    // R8: different tag at same index replaces the entry
    update(mk(9, 3), 1'b1, 32'h0000_9999);
    lookup(mk(7, 3), 1'b0, 1'b0, '0, "R8");
    chk("R8", "old tag evicted", 64'(rh0), 64'd0);
    lookup(mk(9, 3), 1'b0, 1'b0, '0, "R8");
    // R5: not-taken on another tag leaves the entry alone
    update(mk(11, 3), 1'b0, 32'h0);
    lookup(mk(9, 3), 1'b0, 1'b0, '0, "R5");
    chk("R5", "entry kept", 64'(rh0 & rt0), 64'd1);
    // R9: same-edge lookup sees pre-update contents
    update(mk(9, 3), 1'b0, 32'h0);
    lookup(mk(9, 3), 1'b1, 1'b0, 32'h0, "R9");
    chk("R9", "old counter 2 predicted", 64'(rt0), 64'd1);
    lookup(mk(9, 3), 1'b0, 1'b0, '0, "R9");
    lookup(mk(13, 6), 1'b1, 1'b1, 32'h0000_6666, "R9");
    chk("R9", "alloc not yet visible", 64'(rh0), 64'd0);
    lookup(mk(13, 6), 1'b0, 1'b0, '0, "R4");

    // R3 R6 R7: per-index outcome patterns against the reference table
    for (int i = 0; i < ENT; i++) begin
      for (int k = 0; k < 10; k++) begin
        bit tk = ((i * 7 + k * 3 + (k >> 2)) >> 1) & 1;
        update(mk(20 + i, i), tk, TGT_W'(32'h100 * i + k));
        lookup(mk(20 + i, i), 1'b0, 1'b0, '0, "R3");
      end
      lookup(mk(21 + i, i), 1'b0, 1'b0, '0, "R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule